// File: doc/BRIEF.md
# Single-Digit Ternary ALU Slice

This block is a purely combinational arithmetic and logic slice for one ternary digit (trit). It takes two operand trits, each carried as a 2-bit binary code, and an operation code. It returns a result trit, a carry/borrow trit for chaining slices into wider units, and an error flag. The arithmetic group covers half-add, half-subtract, single-digit multiply and three-way magnitude compare. The logic group covers minimum, maximum, modulo-3 sum, and the inverted minimum and inverted maximum formed with each of three ternary inverters.

Trit values are 0, 1 and 2, encoded 2'b00, 2'b01 and 2'b10. The code 2'b11 never names a digit. The slice can be instantiated once per digit position. The carry/borrow trit of one slice is combined in the next position up, either by a second add/subtract slice or by external chain logic.

Top module: `trit_alu_slice`

## Requirements
- R1: If either operand carries code 2'b11, `bad_code` is 1 and both `res_trit` and `cy_trit` are 0, whatever the operation code.
- R2: Operation codes 13, 14 and 15 give `bad_code` = 1 and `res_trit` = `cy_trit` = 0.
- R3: Code 0 (add) gives `res_trit` = (A+B) mod 3 and `cy_trit` = (A+B) div 3.
- R4: Code 1 (subtract) gives `res_trit` = (A−B) mod 3, and `cy_trit` = 1 exactly when A < B, otherwise 0.
- R5: Code 2 (multiply) gives `res_trit` = (A·B) mod 3, and `cy_trit` = 1 only for 2·2, otherwise 0.
- R6: Code 3 (compare) gives `res_trit` = 0 for A<B, 1 for A=B and 2 for A>B.
- R7: Code 4 gives min(A,B) and code 5 gives max(A,B).
- R8: Code 6 (ternary XOR) gives (A+B) mod 3.
- R9: Codes 7, 8 and 9 apply the simple, positive and negative inverter to min(A,B). The simple inverter maps x to 2−x. The positive inverter maps 0 and 1 to 2, and maps 2 to 0. The negative inverter maps 0 to 2, and maps 1 and 2 to 0.
- R10: Codes 10, 11 and 12 apply the simple, positive and negative inverter, in that order, to max(A,B).
- R11: For codes 3 to 12, `cy_trit` is 0.
- R12: `res_trit` and `cy_trit` never carry code 2'b11, and `bad_code` is 0 for every legal operand pair with codes 0 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_trit | input | 2 | Operand A trit code |
| b_trit | input | 2 | Operand B trit code |
| op_sel | input | SEL_W (4) | Operation code |
| res_trit | output | 2 | Result trit code |
| cy_trit | output | 2 | Carry or borrow trit code |
| bad_code | output | 1 | Illegal operand or operation code |

## Verification
The bench builds the slice with its default 4-bit operation code. At that width every code point can be reached: the thirteen defined operations and the three spare codes. All sixteen operation codes are crossed with all sixteen operand code pairs, which includes every pair that carries the forbidden 2'b11 pattern. A short table of hand-worked vectors pins the corner values of each operation. These are the top carry of 2+2, the borrow of 0−2, the lone multiply carry, the three compare outcomes and one case for each inverter family.

// File: rtl/trit_pkg.sv
package trit_pkg;
   typedef logic [1:0] trit_t;

   localparam trit_t TRIT_ZERO = 2'd0;
   localparam trit_t TRIT_ONE  = 2'd1;
   localparam trit_t TRIT_TWO  = 2'd2;
   localparam trit_t TRIT_BAD  = 2'd3;

   localparam int NUM_INV = 3;
   localparam int NUM_OPS = 13;

   typedef enum logic [1:0] {
      INV_SIMPLE = 2'd0,
      INV_POS    = 2'd1,
      INV_NEG    = 2'd2
   } inv_kind_e;

   typedef enum logic [3:0] {
      OP_ADD    = 4'd0,
      OP_SUB    = 4'd1,
      OP_MUL    = 4'd2,
      OP_CMP    = 4'd3,
      OP_MIN    = 4'd4,
      OP_MAX    = 4'd5,
      OP_XOR    = 4'd6,
      OP_NMIN_S = 4'd7,
      OP_NMIN_P = 4'd8,
      OP_NMIN_N = 4'd9,
      OP_NMAX_S = 4'd10,
      OP_NMAX_P = 4'd11,
      OP_NMAX_N = 4'd12
   } op_e;

   function automatic trit_t trit_min(trit_t x, trit_t y);
      return (x < y) ? x : y;
   endfunction

   function automatic trit_t trit_max(trit_t x, trit_t y);
      return (x > y) ? x : y;
   endfunction

   function automatic trit_t trit_inv(inv_kind_e k, trit_t x);
      trit_t r;
      case (k)
         INV_SIMPLE: r = TRIT_TWO - x;
         INV_POS:    r = (x == TRIT_TWO) ? TRIT_ZERO : TRIT_TWO;
         default:    r = (x == TRIT_ZERO) ? TRIT_TWO : TRIT_ZERO;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/trit_arith.sv
module trit_arith
   import trit_pkg::*;
(
   input  trit_t a,
   input  trit_t b,
   output trit_t sum_r,
   output trit_t sum_c,
   output trit_t dif_r,
   output trit_t dif_b,
   output trit_t mul_r,
   output trit_t mul_c,
   output trit_t cmp_r
);
   logic [2:0] raw_sum;
   logic [2:0] raw_dif;
   logic [2:0] raw_mul;

   always_comb begin
      raw_sum = {1'b0, a} + {1'b0, b};
      raw_dif = {1'b0, a} + 3'd3 - {1'b0, b};
      raw_mul = 3'(a * b);

      sum_c = (raw_sum >= 3'd3) ? TRIT_ONE : TRIT_ZERO;
      sum_r = (raw_sum >= 3'd3) ? 2'(raw_sum - 3'd3) : raw_sum[1:0];

      dif_b = (a < b) ? TRIT_ONE : TRIT_ZERO;
      dif_r = (raw_dif >= 3'd3) ? 2'(raw_dif - 3'd3) : raw_dif[1:0];

      mul_c = (raw_mul == 3'd4) ? TRIT_ONE : TRIT_ZERO;
      mul_r = (raw_mul >= 3'd3) ? 2'(raw_mul - 3'd3) : raw_mul[1:0];

      if (a < b)       cmp_r = TRIT_ZERO;
      else if (a == b) cmp_r = TRIT_ONE;
      else             cmp_r = TRIT_TWO;
   end
endmodule

// File: rtl/trit_logic.sv
module trit_logic
   import trit_pkg::*;
(
   input  trit_t a,
   input  trit_t b,
   output trit_t lo,
   output trit_t hi,
   output trit_t xr,
   output trit_t [NUM_INV-1:0] nlo,
   output trit_t [NUM_INV-1:0] nhi
);
   logic [2:0] raw;

   always_comb begin
      lo  = trit_min(a, b);
      hi  = trit_max(a, b);
      raw = {1'b0, a} + {1'b0, b};
      xr  = (raw >= 3'd3) ? 2'(raw - 3'd3) : raw[1:0];
   end

   for (genvar k = 0; k < NUM_INV; k++) begin : g_inv
      localparam inv_kind_e KIND = inv_kind_e'(k);
      assign nlo[k] = trit_inv(KIND, lo);
      assign nhi[k] = trit_inv(KIND, hi);
   end
endmodule

// File: rtl/trit_alu_slice.sv
module trit_alu_slice
   import trit_pkg::*;
#(
   parameter int TRIT_W = 2,
   parameter int SEL_W  = 4
) (
   input  logic [TRIT_W-1:0] a_trit,
   input  logic [TRIT_W-1:0] b_trit,
   input  logic [SEL_W-1:0]  op_sel,
   output logic [TRIT_W-1:0] res_trit,
   output logic [TRIT_W-1:0] cy_trit,
   output logic              bad_code
);
   localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NUM_OPS);

   if (TRIT_W != 2) begin : g_bad_trit_w
      $error("trit_alu_slice: TRIT_W must be 2");
   end
   if (SEL_W < 4) begin : g_bad_sel_w
      $error("trit_alu_slice: SEL_W must be at least 4");
   end

   trit_t sum_r, sum_c, dif_r, dif_b, mul_r, mul_c, cmp_r;
   trit_t lo, hi, xr;
   trit_t [NUM_INV-1:0] nlo;
   trit_t [NUM_INV-1:0] nhi;

   trit_arith u_arith (
      .a(a_trit), .b(b_trit),
      .sum_r(sum_r), .sum_c(sum_c),
      .dif_r(dif_r), .dif_b(dif_b),
      .mul_r(mul_r), .mul_c(mul_c),
      .cmp_r(cmp_r)
   );

   trit_logic u_logic (
      .a(a_trit), .b(b_trit),
      .lo(lo), .hi(hi), .xr(xr),
      .nlo(nlo), .nhi(nhi)
   );

   logic opnd_bad;
   logic sel_bad;
   op_e  op;

   always_comb begin
      opnd_bad = (a_trit == TRIT_BAD) || (b_trit == TRIT_BAD);
      sel_bad  = (op_sel >= SEL_LIMIT);
      op       = op_e'(op_sel[3:0]);
      res_trit = TRIT_ZERO;
      cy_trit  = TRIT_ZERO;
      bad_code = opnd_bad || sel_bad;
      if (!bad_code) begin
         case (op)
            OP_ADD:    begin res_trit = sum_r; cy_trit = sum_c; end
            OP_SUB:    begin res_trit = dif_r; cy_trit = dif_b; end
            OP_MUL:    begin res_trit = mul_r; cy_trit = mul_c; end
            OP_CMP:    res_trit = cmp_r;
            OP_MIN:    res_trit = lo;
            OP_MAX:    res_trit = hi;
            OP_XOR:    res_trit = xr;
            OP_NMIN_S: res_trit = nlo[INV_SIMPLE];
            OP_NMIN_P: res_trit = nlo[INV_POS];
            OP_NMIN_N: res_trit = nlo[INV_NEG];
            OP_NMAX_S: res_trit = nhi[INV_SIMPLE];
            OP_NMAX_P: res_trit = nhi[INV_POS];
            OP_NMAX_N: res_trit = nhi[INV_NEG];
            default:   res_trit = TRIT_ZERO;
         endcase
      end
   end
endmodule

// File: rtl/trit_alu_slice_chk.sv
module trit_alu_slice_chk #(
   parameter int TRIT_W = 2,
   parameter int SEL_W  = 4
) (
   input logic [TRIT_W-1:0] a_trit,
   input logic [TRIT_W-1:0] b_trit,
   input logic [SEL_W-1:0]  op_sel,
   input logic [TRIT_W-1:0] res_trit,
   input logic [TRIT_W-1:0] cy_trit,
   input logic              bad_code
);
   always_comb begin
      if (!$isunknown({a_trit, b_trit, op_sel})) begin
         // R1
         illegal_operand_chk: assert (!((a_trit == 2'd3) || (b_trit == 2'd3)) ||
                                      (bad_code && res_trit == 2'd0 && cy_trit == 2'd0));
         // R2
         spare_opcode_chk: assert (!(int'(op_sel) > 12) || (bad_code && res_trit == 2'd0));
         // R12
         legal_output_chk: assert (res_trit != 2'd3 && cy_trit != 2'd3);
         // R3
         add_value_chk: assert (bad_code || op_sel != 0 ||
                                (int'(res_trit) + 3 * int'(cy_trit) == int'(a_trit) + int'(b_trit)));
         // R11
         no_carry_logic_chk: assert (int'(op_sel) < 3 || cy_trit == 2'd0);
         // R6
         cmp_equal_chk: assert (bad_code || op_sel != 3 || a_trit != b_trit || res_trit == 2'd1);
      end
   end
endmodule

bind trit_alu_slice trit_alu_slice_chk #(.TRIT_W(TRIT_W), .SEL_W(SEL_W)) u_chk (
   .a_trit(a_trit), .b_trit(b_trit), .op_sel(op_sel),
   .res_trit(res_trit), .cy_trit(cy_trit), .bad_code(bad_code)
);

// File: tb/tb_trit_alu_slice.sv
module tb_trit_alu_slice;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [1:0] a_trit, b_trit, res_trit, cy_trit;
   logic [3:0] op_sel;
   logic       bad_code;
   int checks = 0;
   int failures = 0;

   trit_alu_slice dut (
      .a_trit(a_trit), .b_trit(b_trit), .op_sel(op_sel),
      .res_trit(res_trit), .cy_trit(cy_trit), .bad_code(bad_code)
   );

   // {op, a, b, exp_res, exp_cy, exp_err}
   localparam logic [12:0] VEC [20] = '{
      {4'd0,  2'd2, 2'd2, 2'd1, 2'd1, 1'b0},
      {4'd0,  2'd1, 2'd1, 2'd2, 2'd0, 1'b0},
      {4'd1,  2'd0, 2'd2, 2'd1, 2'd1, 1'b0},
      {4'd1,  2'd2, 2'd1, 2'd1, 2'd0, 1'b0},
      {4'd2,  2'd2, 2'd2, 2'd1, 2'd1, 1'b0},
      {4'd2,  2'd2, 2'd1, 2'd2, 2'd0, 1'b0},
      {4'd3,  2'd0, 2'd2, 2'd0, 2'd0, 1'b0},
      {4'd3,  2'd2, 2'd2, 2'd1, 2'd0, 1'b0},
      {4'd3,  2'd2, 2'd0, 2'd2, 2'd0, 1'b0},
      {4'd4,  2'd2, 2'd1, 2'd1, 2'd0, 1'b0},
      {4'd5,  2'd0, 2'd1, 2'd1, 2'd0, 1'b0},
      {4'd6,  2'd2, 2'd2, 2'd1, 2'd0, 1'b0},
      {4'd7,  2'd2, 2'd2, 2'd0, 2'd0, 1'b0},
      {4'd8,  2'd1, 2'd2, 2'd2, 2'd0, 1'b0},
      {4'd9,  2'd1, 2'd2, 2'd0, 2'd0, 1'b0},
      {4'd10, 2'd0, 2'd1, 2'd1, 2'd0, 1'b0},
      {4'd11, 2'd0, 2'd2, 2'd0, 2'd0, 1'b0},
      {4'd12, 2'd0, 2'd0, 2'd2, 2'd0, 1'b0},
      {4'd13, 2'd1, 2'd1, 2'd0, 2'd0, 1'b1},
      {4'd0,  2'd3, 2'd0, 2'd0, 2'd0, 1'b1}
   };

   function automatic string tag_of(int op, int a, int b);
      if (a == 3 || b == 3) return "R1";
      case (op)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4, 5: return "R7";
         6: return "R8";
         7, 8, 9: return "R9";
         10, 11, 12: return "R10";
         default: return "R2";
      endcase
   endfunction

   function automatic int inv_ref(int kind, int x);
      if (kind == 0) return 2 - x;
      if (kind == 1) return (x == 2) ? 0 : 2;
      return (x == 0) ? 2 : 0;
   endfunction

   task automatic ref_model(input int op, input int a, input int b,
                            output int r, output int c, output int e);
      int mn, mx;
      r = 0; c = 0; e = 0;
      mn = (a < b) ? a : b;
      mx = (a > b) ? a : b;
      if (a == 3 || b == 3 || op > 12) begin
         e = 1;
      end else begin
         case (op)
            0: begin r = (a + b) % 3; c = (a + b) / 3; end
            1: begin r = (a - b + 3) % 3; c = (a < b) ? 1 : 0; end
            2: begin r = (a * b) % 3; c = (a * b == 4) ? 1 : 0; end
            3: r = (a < b) ? 0 : ((a == b) ? 1 : 2);
            4: r = mn;
            5: r = mx;
            6: r = (a + b) % 3;
            7, 8, 9: r = inv_ref(op - 7, mn);
            default: r = inv_ref(op - 10, mx);
         endcase
      end
   endtask

   task automatic apply_and_check(input string tag, input int op, input int a, input int b,
                                  input int er, input int ec, input int ee);
      @(posedge clk);
      op_sel = 4'(op); a_trit = 2'(a); b_trit = 2'(b);
      @(negedge clk);
      checks++;
      if (int'(res_trit) != er || int'(cy_trit) != ec || int'(bad_code) != ee) begin
         failures++;
         $display("FAIL %s op=%0d a=%0d b=%0d actual res=%0d cy=%0d err=%0d expected res=%0d cy=%0d err=%0d",
                  tag, op, a, b, res_trit, cy_trit, bad_code, er, ec, ee);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      a_trit = 2'd0; b_trit = 2'd0; op_sel = 4'd0;
      repeat (3) @(posedge clk);
      // reset state: zero operands under add give zero result, no error (R3)
      @(negedge clk);
      checks++;
      if (res_trit !== 2'd0 || cy_trit !== 2'd0 || bad_code !== 1'b0) begin
         failures++;
         $display("FAIL R3 reset actual res=%0d cy=%0d err=%0d expected res=0 cy=0 err=0",
                  res_trit, cy_trit, bad_code);
      end
      rst = 1'b0;

      foreach (VEC[i]) begin
         logic [12:0] v;
         v = VEC[i];
         apply_and_check(tag_of(int'(v[12:9]), int'(v[8:7]), int'(v[6:5])),
                         int'(v[12:9]), int'(v[8:7]), int'(v[6:5]),
                         int'(v[4:3]), int'(v[2:1]), int'(v[0]));
      end

      // full sweep including spare codes and 2'b11 operands (R1, R2, R11, R12)
      for (int op = 0; op < 16; op++) begin
         for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
               int r, c, e;
               ref_model(op, a, b, r, c, e);
               apply_and_check(tag_of(op, a, b), op, a, b, r, c, e);
               checks++;
               if (res_trit == 2'd3 || cy_trit == 2'd3) begin
                  failures++;
                  $display("FAIL R12 op=%0d actual res=%0d cy=%0d expected legal codes",
                           op, res_trit, cy_trit);
               end
            end
         end
      end

      // carry/borrow idle on compare and logic codes (R11)
      apply_and_check("R11", 12, 2, 2, 0, 0, 0);
      apply_and_check("R11", 3, 1, 2, 0, 0, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule